// File: doc/BRIEF.md
# IN Endpoint Handshake and Toggle Control

This block decides how one IN endpoint of a USB device answers each IN token from the host. For each token it chooses between sending data and sending NAK, and it keeps the endpoint's DATA0/DATA1 sequence bit. The CPU marks the buffer ready with a one-cycle set pulse. The packet engine tells the block how the transaction ended: the host acknowledged, or the handshake timed out.

There are two modes. In normal mode, interrupt endpoints behave exactly like bulk endpoints. Data is sent only when the buffer is ready, and the sequence bit advances only on an acknowledge. In rate-feedback mode, selected with a control bit and meant for a single-buffered endpoint, the block always has something to send. It never NAKs, it sends the current data whatever the buffer-ready flag says, and it advances the sequence bit after every packet sent, whatever handshake comes back. If feedback is requested while single-buffer mode is off, the block raises a sticky configuration error and behaves as in normal mode.

The controller has four states. IDLE waits for a token. SEND drives the one-cycle send-data decision. NAK drives the one-cycle NAK decision. WAIT_HS waits for the handshake outcome. The transitions are: IDLE to SEND on a token when data may go out, IDLE to NAK on a token when it may not, SEND to WAIT_HS always, NAK to IDLE always, and WAIT_HS to IDLE on an acknowledge or a timeout.

Top module: `ep_in_handshake`

## Requirements
- R1: After reset, toggle is 0 (DATA0), buf_rdy is 0, cfg_err is 0, and both send_data and send_nak are 0.
- R2: In normal mode, an IN token seen in IDLE while buf_rdy is 0 raises send_nak for exactly the next cycle, does not raise send_data, and leaves toggle unchanged.
- R3: An IN token seen in IDLE while data may go out raises send_data for exactly the next cycle. In normal mode toggle is unchanged at that point.
- R4: In normal mode, an acknowledge while waiting for the handshake inverts toggle and clears buf_rdy in the following cycle.
- R5: In normal mode, a timeout while waiting leaves toggle and buf_rdy unchanged, so a repeated token resends the data with the same toggle.
- R6: In feedback mode (fb_en=1 and single_buf=1), every IN token seen in IDLE raises send_data and never send_nak, whatever the value of buf_rdy.
- R7: In feedback mode, toggle inverts in the cycle after the send_data cycle, and the following acknowledge or timeout does not change toggle.
- R8: In feedback mode, buf_rdy is cleared in the cycle after the send_data cycle.
- R9: Whenever fb_en=1 while single_buf=0, cfg_err is set from the next cycle and stays set until reset. In that case tokens are answered as in normal mode.
- R10: An IN token outside IDLE, and an acknowledge or timeout outside the handshake wait, are ignored. They produce no send_data, no send_nak and no change of toggle.
- R11: The mode is sampled when a token is accepted. A change of fb_en during the transaction does not alter how that transaction updates toggle and buf_rdy.
- R12: buf_set sets buf_rdy in the next cycle. If a clear happens in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_token | input | 1 | One-cycle pulse: the host sent an IN token to this endpoint |
| hs_ack | input | 1 | One-cycle pulse: the host acknowledged the packet |
| hs_timeout | input | 1 | One-cycle pulse: no handshake arrived in time |
| buf_set | input | 1 | One-cycle pulse from the CPU: the buffer holds new data |
| single_buf | input | 1 | Endpoint runs in single-buffer mode |
| fb_en | input | 1 | Requests rate-feedback mode |
| send_data | output | 1 | One-cycle decision: send a data packet |
| send_nak | output | 1 | One-cycle decision: send NAK |
| toggle | output | 1 | Current data PID sequence bit (0 = DATA0, 1 = DATA1) |
| buf_rdy | output | 1 | Buffer-ready status |
| cfg_err | output | 1 | Sticky flag: feedback was requested without single-buffer mode |

## Verification
The assertions assume that the packet engine reports at most one handshake outcome per transaction, never both in the same cycle, and reports it only after a send_data decision. They also assume that the mode inputs are sampled at the token. The checker rebuilds the transaction phase from the ports alone and only judges handshakes that arrive inside its own wait window. The directed stimulus therefore sends outcomes only while waiting, except for the one scenario that deliberately injects stray tokens and handshakes to show that they are ignored.

// File: rtl/ep_hs_pkg.sv
`timescale 1ns/1ps
package ep_hs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_NAK  = 2'd2,
        ST_WAIT = 2'd3
    } ep_state_t;
endpackage

// File: rtl/ep_mode_cfg.sv
`timescale 1ns/1ps
// Resolves the effective mode and holds the sticky configuration error.
module ep_mode_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_en,
    input  logic single_buf,
    output logic fb_eff,
    output logic cfg_err
);
    logic bad_cfg;

    always_comb begin
        bad_cfg = fb_en && !single_buf;
        fb_eff  = fb_en && single_buf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (bad_cfg) begin
            cfg_err <= 1'b1;
        end
    end
endmodule

// File: rtl/ep_hs_fsm.sv
`timescale 1ns/1ps
// Token response state machine; latches the mode per transaction.
module ep_hs_fsm
    import ep_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_token,
    input  logic hs_ack,
    input  logic hs_timeout,
    input  logic fb_eff,
    input  logic buf_rdy,
    output logic fb_lat,
    output logic send_data,
    output logic send_nak,
    output logic ev_sent,
    output logic ev_ack
);
    ep_state_t state_q, state_d;
    logic      may_send;

    always_comb begin
        may_send = fb_eff || buf_rdy;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_token) begin
                    state_d = may_send ? ST_SEND : ST_NAK;
                end
            end
            ST_SEND: state_d = ST_WAIT;
            ST_NAK:  state_d = ST_IDLE;
            ST_WAIT: begin
                if (hs_ack || hs_timeout) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fb_lat  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && in_token) begin
                fb_lat <= fb_eff;
            end
        end
    end

    always_comb begin
        send_data = 1'b0;
        send_nak  = 1'b0;
        ev_sent   = 1'b0;
        ev_ack    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SEND: begin
                send_data = 1'b1;
                ev_sent   = 1'b1;
            end
            ST_NAK:  send_nak = 1'b1;
            ST_WAIT: ev_ack = hs_ack;
            default: ;
        endcase
    end
endmodule

// File: rtl/ep_seq_flags.sv
`timescale 1ns/1ps
// Sequence bit and buffer-ready flag.
module ep_seq_flags #(
    parameter bit INIT_TOGGLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic buf_set,
    input  logic fb_lat,
    input  logic ev_sent,
    input  logic ev_ack,
    output logic toggle,
    output logic buf_rdy
);
    logic advance;

    always_comb begin
        advance = fb_lat ? ev_sent : ev_ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            toggle  <= INIT_TOGGLE;
            buf_rdy <= 1'b0;
        end else begin
            if (advance) begin
                toggle <= !toggle;
            end
            if (buf_set) begin
                buf_rdy <= 1'b1;
            end else if (advance) begin
                buf_rdy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ep_in_handshake.sv
`timescale 1ns/1ps
module ep_in_handshake #(
    parameter bit INIT_TOGGLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_token,
    input  logic hs_ack,
    input  logic hs_timeout,
    input  logic buf_set,
    input  logic single_buf,
    input  logic fb_en,
    output logic send_data,
    output logic send_nak,
    output logic toggle,
    output logic buf_rdy,
    output logic cfg_err
);
    logic fb_eff;
    logic fb_lat;
    logic ev_sent;
    logic ev_ack;

    ep_mode_cfg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .fb_en      (fb_en),
        .single_buf (single_buf),
        .fb_eff     (fb_eff),
        .cfg_err    (cfg_err)
    );

    ep_hs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_token   (in_token),
        .hs_ack     (hs_ack),
        .hs_timeout (hs_timeout),
        .fb_eff     (fb_eff),
        .buf_rdy    (buf_rdy),
        .fb_lat     (fb_lat),
        .send_data  (send_data),
        .send_nak   (send_nak),
        .ev_sent    (ev_sent),
        .ev_ack     (ev_ack)
    );

    ep_seq_flags #(.INIT_TOGGLE(INIT_TOGGLE)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .buf_set (buf_set),
        .fb_lat  (fb_lat),
        .ev_sent (ev_sent),
        .ev_ack  (ev_ack),
        .toggle  (toggle),
        .buf_rdy (buf_rdy)
    );
endmodule

// File: rtl/ep_in_handshake_chk.sv
`timescale 1ns/1ps
// Port-level checker; rebuilds the transaction phase from the ports.
module ep_in_handshake_chk (
    input logic clk,
    input logic rst_n,
    input logic in_token,
    input logic hs_ack,
    input logic hs_timeout,
    input logic buf_set,
    input logic single_buf,
    input logic fb_en,
    input logic send_data,
    input logic send_nak,
    input logic toggle,
    input logic buf_rdy,
    input logic cfg_err
);
    logic cb_busy;
    logic cb_wait;
    logic cb_fb;
    logic hs_any;

    always_comb hs_any = hs_ack || hs_timeout;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cb_busy <= 1'b0;
            cb_wait <= 1'b0;
            cb_fb   <= 1'b0;
        end else begin
            if (!cb_busy && in_token) begin
                cb_busy <= 1'b1;
                cb_fb   <= fb_en && single_buf;
            end else if (send_nak || (cb_wait && hs_any)) begin
                cb_busy <= 1'b0;
            end
            if (send_data) begin
                cb_wait <= 1'b1;
            end else if (cb_wait && hs_any) begin
                cb_wait <= 1'b0;
            end
        end
    end

    a_r2_nak_only_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        send_nak |-> $past(!buf_rdy && !(fb_en && single_buf)));

    a_r3_data_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        send_data |=> !send_data);

    a_r4_ack_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_wait && hs_ack && !cb_fb) |=> (toggle != $past(toggle)));

    a_r5_timeout_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_wait && hs_timeout && !cb_fb) |=> $stable(toggle));

    a_r6_feedback_no_nak: assert property (@(posedge clk) disable iff (!rst_n)
        send_nak |-> !$past(fb_en && single_buf));

    a_r7_feedback_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (send_data && cb_fb) |=> (toggle != $past(toggle)));

    a_r8_feedback_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (send_data && cb_fb && !buf_set) |=> !buf_rdy);

    a_r9_cfg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        buf_set |=> buf_rdy);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_data && send_nak));
endmodule

bind ep_in_handshake ep_in_handshake_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_token   (in_token),
    .hs_ack     (hs_ack),
    .hs_timeout (hs_timeout),
    .buf_set    (buf_set),
    .single_buf (single_buf),
    .fb_en      (fb_en),
    .send_data  (send_data),
    .send_nak   (send_nak),
    .toggle     (toggle),
    .buf_rdy    (buf_rdy),
    .cfg_err    (cfg_err)
);

// File: tb/test_ep_in_handshake.sv
`timescale 1ns/1ps
module test_ep_in_handshake;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_token = 1'b0, hs_ack = 1'b0, hs_timeout = 1'b0, buf_set = 1'b0;
    logic single_buf = 1'b1, fb_en = 1'b0;
    logic send_data, send_nak, toggle, buf_rdy, cfg_err;

    int checks = 0;
    int failures = 0;
    logic exp_tog = 1'b0;

    always #5 clk = !clk;

    ep_in_handshake i_ep_in_handshake (
        .clk(clk), .rst_n(rst_n), .in_token(in_token), .hs_ack(hs_ack),
        .hs_timeout(hs_timeout), .buf_set(buf_set), .single_buf(single_buf),
        .fb_en(fb_en), .send_data(send_data), .send_nak(send_nak),
        .toggle(toggle), .buf_rdy(buf_rdy), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic token();
        in_token = 1'b1; tick(); in_token = 1'b0;
    endtask

    task automatic ack();
        hs_ack = 1'b1; tick(); hs_ack = 1'b0;
    endtask

    task automatic tmo();
        hs_timeout = 1'b1; tick(); hs_timeout = 1'b0;
    endtask

    task automatic bset();
        buf_set = 1'b1; tick(); buf_set = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 toggle", toggle, 1'b0);
        check("R1 buf_rdy", buf_rdy, 1'b0);
        check("R1 cfg_err", cfg_err, 1'b0);
        check("R1 send_data", send_data, 1'b0);
        check("R1 send_nak", send_nak, 1'b0);
    endtask

    task automatic t_nak();
        token();
        check("R2 nak raised", send_nak, 1'b1);
        check("R2 no data", send_data, 1'b0);
        tick();
        check("R2 nak one cycle", send_nak, 1'b0);
        check("R2 toggle held", toggle, exp_tog);
    endtask

    task automatic t_send_ack();
        bset();
        check("R12 set", buf_rdy, 1'b1);
        token();
        check("R3 data raised", send_data, 1'b1);
        check("R3 no nak", send_nak, 1'b0);
        tick();
        check("R3 data one cycle", send_data, 1'b0);
        check("R3 toggle held", toggle, exp_tog);
        ack(); exp_tog = !exp_tog;
        check("R4 toggle advanced", toggle, exp_tog);
        check("R4 buf cleared", buf_rdy, 1'b0);
    endtask

    task automatic t_timeout();
        bset();
        token(); tick();
        tmo();
        check("R5 toggle held", toggle, exp_tog);
        check("R5 buf held", buf_rdy, 1'b1);
        token();
        check("R5 resend", send_data, 1'b1);
        tick();
        ack(); exp_tog = !exp_tog;
        check("R5 then ack advances", toggle, exp_tog);
    endtask

    task automatic t_ignore();
        ack();
        check("R10 stray ack toggle", toggle, exp_tog);
        tmo();
        check("R10 stray timeout", send_data, 1'b0);
        bset();
        token();
        in_token = 1'b1; tick();
        check("R10 token in send", send_data, 1'b0);
        tick(); in_token = 1'b0;
        check("R10 token in wait data", send_data, 1'b0);
        check("R10 token in wait nak", send_nak, 1'b0);
        ack(); exp_tog = !exp_tog;
        check("R10 single advance", toggle, exp_tog);
    endtask

    task automatic t_feedback();
        fb_en = 1'b1; single_buf = 1'b1;
        token();
        check("R6 data with empty buf", send_data, 1'b1);
        check("R6 no nak", send_nak, 1'b0);
        tick(); exp_tog = !exp_tog;
        check("R7 advance after send", toggle, exp_tog);
        tmo();
        check("R7 timeout no change", toggle, exp_tog);
        bset();
        token(); tick(); exp_tog = !exp_tog;
        check("R8 buf cleared", buf_rdy, 1'b0);
        check("R7 advance again", toggle, exp_tog);
        ack();
        check("R7 ack no change", toggle, exp_tog);
        fb_en = 1'b0;
    endtask

    task automatic t_latch();
        fb_en = 1'b1;
        token(); fb_en = 1'b0;
        tick(); exp_tog = !exp_tog;
        check("R11 feedback kept", toggle, exp_tog);
        tmo();
        bset();
        token(); fb_en = 1'b1;
        tick();
        check("R11 normal kept", toggle, exp_tog);
        fb_en = 1'b0;
        ack(); exp_tog = !exp_tog;
        check("R11 normal ack", toggle, exp_tog);
        check("R11 normal clear", buf_rdy, 1'b0);
    endtask

    task automatic t_cfgerr();
        single_buf = 1'b0; fb_en = 1'b1;
        tick();
        check("R9 cfg_err set", cfg_err, 1'b1);
        token();
        check("R9 falls back to nak", send_nak, 1'b1);
        tick();
        fb_en = 1'b0; single_buf = 1'b1;
        tick();
        check("R9 sticky", cfg_err, 1'b1);
    endtask

    task automatic t_setwins();
        bset();
        token(); tick();
        hs_ack = 1'b1; buf_set = 1'b1; tick(); hs_ack = 1'b0; buf_set = 1'b0;
        exp_tog = !exp_tog;
        check("R12 set beats clear", buf_rdy, 1'b1);
        check("R12 toggle advanced", toggle, exp_tog);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_nak();
        t_send_ack();
        t_timeout();
        t_ignore();
        t_feedback();
        t_latch();
        t_cfgerr();
        t_setwins();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule